// File: doc/BRIEF.md
# Interrupt Line Redirection and Thread Dispatch Controller

This block collects a bank of hardware interrupt lines and turns each accepted request into a vector bit in the pending word of one hardware thread. Every line owns a small redirection entry. The entry decides whether the line may request at all. It also sets whether the line is edge or level sensitive, and which of the 64 vectors the line raises. Finally it selects the threads that may receive it, and whether the thread choice follows a pointer kept per line or one pointer shared by the whole block. A line whose entry has the non-maskable flag set pulses a per-thread NMI output instead of setting a pending bit.

When several lines request in the same cycle, the lowest-numbered line wins and the others wait. After delivery a line is held in service and cannot request again until software writes its number to the acknowledge port. Software acknowledges an edge line at once, so that an edge seen while the line is held is latched and not lost. It acknowledges a level line after the handler has run. Each thread reads its pending word and clears bits by writing ones. A thread-enable mask removes threads from selection.

Top module: `irq_redirect_ctrl`

## Requirements
- R1: After reset every pending bit and every NMI output is 0, all threads are enabled, and every redirection entry is disabled.
- R2: An entry is written as a 32-bit word at address = line index, with enable at bit 0, NMI at bit 1, pointer mode at bit 2 (0 = per-line pointer, 1 = shared pointer), trigger at bit 3 (0 = level, 1 = edge), vector at bits 9:4 and thread affinity at bits 16+N_THREADS-1:16. A line whose enable bit is 0 never sets a pending bit or pulses an NMI output.
- R3: A level line held high sets the pending bit at its vector in the pending word of the chosen thread, on the second rising clock edge after the input rises. The pending word of thread t is pend_o[t*64 +: 64].
- R4: After delivery a line raises nothing more until its index is written to the acknowledge port; a level line still high after the acknowledge is delivered again.
- R5: An edge line delivers once per rising edge of its input, however long the input stays high. A rising edge that arrives while the line is in service is kept and delivered after the acknowledge.
- R6: When several lines request in the same cycle, the lowest line index is delivered first and only one delivery happens per cycle.
- R7: Lines in shared-pointer mode take the next permitted thread after the last thread that any shared-pointer delivery used, wrapping around; after reset the first such delivery goes to the lowest permitted thread.
- R8: Lines in per-line mode take the next permitted thread after the last thread that the same line used, unaffected by other lines.
- R9: A thread is permitted only when it is both in the line's affinity and enabled. A request with no permitted thread waits without blocking other lines, and is delivered once a thread becomes permitted.
- R10: A delivery from an entry with the NMI bit set drives the chosen thread's nmi_o bit high for exactly one cycle and leaves all pending words unchanged.
- R11: A clear write removes the pending bits of the addressed thread that are 1 in the mask. When a delivery sets a bit that a clear removes in the same cycle, the bit ends set.
- R12: The thread-enable mask is written through its own strobe; a thread whose bit is 0 is skipped by both pointer modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | N_LINES | Interrupt request lines |
| cfg_we_i | input | 1 | Redirection entry write strobe |
| cfg_addr_i | input | clog2(N_LINES) | Line index of the entry written |
| cfg_wdata_i | input | 32 | Entry value |
| thr_en_we_i | input | 1 | Thread-enable mask write strobe |
| thr_en_wdata_i | input | N_THREADS | New thread-enable mask |
| ack_we_i | input | 1 | Acknowledge write strobe |
| ack_line_i | input | clog2(N_LINES) | Line index taken out of service |
| clr_we_i | input | 1 | Pending clear write strobe |
| clr_thr_i | input | clog2(N_THREADS) | Thread whose pending word is cleared |
| clr_mask_i | input | 64 | Write-one-to-clear mask |
| pend_o | output | N_THREADS*64 | Pending words, thread t at bits t*64+63:t*64 |
| nmi_o | output | N_THREADS | One-cycle NMI pulse per thread |

## Verification
On every cycle the assertions check a set of local rules. A delivery always finds a permitted thread, and that thread is both enabled and in the affinity. A delivered line is in service on the next cycle and stays there until it is acknowledged. A non-NMI delivery lands in the pending word, and an NMI delivery leaves the pending words untouched. At most one NMI output is high. What a property cannot see is the order across many events: the wrap of both pointer kinds, the choice of the lowest line, an edge kept across the in-service window, a request that resumes after its thread is enabled, and the collision of a set with a clear. The bench's scenarios show these at the ports of a small instance, sweeping every line.

// File: rtl/irq_rd_pkg.sv
package irq_rd_pkg;
  localparam int VEC_W     = 6;
  localparam int N_VEC     = 64;
  localparam int AFF_LSB   = 16;
  localparam int AFF_MAX   = 16;
  localparam int EN_BIT    = 0;
  localparam int NMI_BIT   = 1;
  localparam int SCHED_BIT = 2;
  localparam int TRIG_BIT  = 3;
  localparam int VEC_LSB   = 4;

  typedef enum logic {SCHED_LOCAL = 1'b0, SCHED_GLOBAL = 1'b1} sched_e;
  typedef enum logic {TRIG_LEVEL = 1'b0, TRIG_EDGE = 1'b1} trig_e;
endpackage

// File: rtl/irq_rd_prio_arb.sv
module irq_rd_prio_arb #(
  parameter int N = 160,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] req_i,
  output logic         gnt_v_o,
  output logic [W-1:0] gnt_idx_o
);
  // lowest index wins
  always_comb begin
    gnt_v_o   = 1'b0;
    gnt_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_v_o   = 1'b1;
        gnt_idx_o = W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_rd_rr_pick.sv
module irq_rd_rr_pick #(
  parameter int N = 8,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] elig_i,
  input  logic [W-1:0] last_i,
  output logic         pick_v_o,
  output logic [W-1:0] pick_o
);
  int c;
  // first eligible slot strictly after last_i, wrapping
  always_comb begin
    pick_v_o = 1'b0;
    pick_o   = '0;
    c        = 0;
    for (int k = N; k >= 1; k--) begin
      c = (int'(last_i) + k) % N;
      if (elig_i[c]) begin
        pick_v_o = 1'b1;
        pick_o   = W'(c);
      end
    end
  end
endmodule

// File: rtl/irq_rd_line_bank.sv
module irq_rd_line_bank
  import irq_rd_pkg::*;
#(
  parameter int N_LINES   = 160,
  parameter int N_THREADS = 8,
  parameter int LINE_W    = $clog2(N_LINES),
  parameter int THR_W     = $clog2(N_THREADS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_LINES-1:0]   line_i,
  input  logic                 cfg_we_i,
  input  logic [LINE_W-1:0]    cfg_addr_i,
  input  logic [31:0]          cfg_wdata_i,
  input  logic                 ack_we_i,
  input  logic [LINE_W-1:0]    ack_line_i,
  input  logic [N_THREADS-1:0] thr_en_i,
  input  logic                 dlv_i,
  input  logic [LINE_W-1:0]    win_line_i,
  input  logic [THR_W-1:0]     dlv_thr_i,
  output logic [N_LINES-1:0]   req_o,
  output logic                 sel_nmi_o,
  output sched_e               sel_sched_o,
  output logic [VEC_W-1:0]     sel_vec_o,
  output logic [N_THREADS-1:0] sel_aff_o,
  output logic [THR_W-1:0]     sel_lptr_o
);
  logic [N_LINES-1:0]   en_q, nmi_q, trig_q, line_q, edge_q, insvc_q;
  sched_e               sched_q [N_LINES];
  logic [VEC_W-1:0]     vec_q   [N_LINES];
  logic [N_THREADS-1:0] aff_q   [N_LINES];
  logic [THR_W-1:0]     lptr_q  [N_LINES];
  logic [N_LINES-1:0]   hit, rise, src;

  // redirection table
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_LINES; i++) begin
        en_q[i]    <= 1'b0;
        nmi_q[i]   <= 1'b0;
        trig_q[i]  <= 1'b0;
        sched_q[i] <= SCHED_LOCAL;
        vec_q[i]   <= '0;
        aff_q[i]   <= '0;
      end
    end else begin
      for (int i = 0; i < N_LINES; i++) begin
        if (cfg_we_i && cfg_addr_i == LINE_W'(i)) begin
          en_q[i]    <= cfg_wdata_i[EN_BIT];
          nmi_q[i]   <= cfg_wdata_i[NMI_BIT];
          trig_q[i]  <= cfg_wdata_i[TRIG_BIT];
          sched_q[i] <= sched_e'(cfg_wdata_i[SCHED_BIT]);
          vec_q[i]   <= cfg_wdata_i[VEC_LSB +: VEC_W];
          aff_q[i]   <= cfg_wdata_i[AFF_LSB +: N_THREADS];
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_LINES; i++) begin
      hit[i]   = dlv_i && (win_line_i == LINE_W'(i));
      rise[i]  = line_i[i] & ~line_q[i] & en_q[i] & trig_q[i];
      src[i]   = trig_q[i] ? edge_q[i] : line_q[i];
      req_o[i] = src[i] & ~insvc_q[i] & en_q[i] & (|(aff_q[i] & thr_en_i));
    end
  end

  // per-line request state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q  <= '0;
      edge_q  <= '0;
      insvc_q <= '0;
      for (int i = 0; i < N_LINES; i++) lptr_q[i] <= THR_W'(N_THREADS - 1);
    end else begin
      line_q <= line_i;
      for (int i = 0; i < N_LINES; i++) begin
        // a new edge outranks the delivery of the old one
        if (rise[i])     edge_q[i] <= 1'b1;
        else if (hit[i]) edge_q[i] <= 1'b0;
        if (hit[i])      insvc_q[i] <= 1'b1;
        else if (ack_we_i && ack_line_i == LINE_W'(i)) insvc_q[i] <= 1'b0;
        if (hit[i] && sched_q[i] == SCHED_LOCAL) lptr_q[i] <= dlv_thr_i;
      end
    end
  end

  assign sel_nmi_o   = nmi_q[win_line_i];
  assign sel_sched_o = sched_q[win_line_i];
  assign sel_vec_o   = vec_q[win_line_i];
  assign sel_aff_o   = aff_q[win_line_i];
  assign sel_lptr_o  = lptr_q[win_line_i];

  for (genvar g = 0; g < N_LINES; g++) begin : g_chk
    p_insvc_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dlv_i && win_line_i == LINE_W'(g)) |=> insvc_q[g]);
    p_insvc_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (insvc_q[g] && !(ack_we_i && ack_line_i == LINE_W'(g))) |=> insvc_q[g]);
  end
endmodule

// File: rtl/irq_rd_pend_bank.sv
module irq_rd_pend_bank
  import irq_rd_pkg::*;
#(
  parameter int N_THREADS = 8,
  parameter int THR_W     = $clog2(N_THREADS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       set_v_i,
  input  logic                       nmi_v_i,
  input  logic [THR_W-1:0]           thr_i,
  input  logic [VEC_W-1:0]           vec_i,
  input  logic                       clr_we_i,
  input  logic [THR_W-1:0]           clr_thr_i,
  input  logic [N_VEC-1:0]           clr_mask_i,
  output logic [N_THREADS*N_VEC-1:0] pend_o,
  output logic [N_THREADS-1:0]       nmi_o
);
  logic [N_THREADS-1:0][N_VEC-1:0] pend_q;
  logic [N_THREADS-1:0][N_VEC-1:0] clr_m, set_m;
  logic [N_THREADS-1:0]            nmi_q;

  always_comb begin
    for (int t = 0; t < N_THREADS; t++) begin
      clr_m[t] = (clr_we_i && clr_thr_i == THR_W'(t)) ? clr_mask_i : '0;
      set_m[t] = (set_v_i && thr_i == THR_W'(t)) ? (N_VEC'(1) << vec_i) : '0;
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      nmi_q  <= '0;
    end else begin
      for (int t = 0; t < N_THREADS; t++) begin
        pend_q[t] <= (pend_q[t] & ~clr_m[t]) | set_m[t];
        nmi_q[t]  <= nmi_v_i && thr_i == THR_W'(t);
      end
    end
  end

  assign pend_o = pend_q;
  assign nmi_o  = nmi_q;

  logic                   last_set_q;
  logic [THR_W+VEC_W-1:0] last_idx_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_set_q <= 1'b0;
      last_idx_q <= '0;
    end else begin
      last_set_q <= set_v_i;
      last_idx_q <= {thr_i, vec_i};
    end
  end

  p_set_lands_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_set_q |-> pend_o[last_idx_q]);
  p_nmi_no_pend_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_v_i && !clr_we_i) |=> pend_q == $past(pend_q));
  p_nmi_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(nmi_o));
endmodule

// File: rtl/irq_redirect_ctrl.sv
module irq_redirect_ctrl
  import irq_rd_pkg::*;
#(
  parameter int N_LINES   = 160,
  parameter int N_THREADS = 8,
  localparam int LINE_W   = $clog2(N_LINES),
  localparam int THR_W    = $clog2(N_THREADS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_LINES-1:0]         line_i,
  input  logic                       cfg_we_i,
  input  logic [LINE_W-1:0]          cfg_addr_i,
  input  logic [31:0]                cfg_wdata_i,
  input  logic                       thr_en_we_i,
  input  logic [N_THREADS-1:0]       thr_en_wdata_i,
  input  logic                       ack_we_i,
  input  logic [LINE_W-1:0]          ack_line_i,
  input  logic                       clr_we_i,
  input  logic [THR_W-1:0]           clr_thr_i,
  input  logic [N_VEC-1:0]           clr_mask_i,
  output logic [N_THREADS*N_VEC-1:0] pend_o,
  output logic [N_THREADS-1:0]       nmi_o
);
  logic [N_THREADS-1:0] thr_en_q;
  logic [THR_W-1:0]     gptr_q;
  logic [N_LINES-1:0]   req;
  logic                 arb_v, pick_v, dlv;
  logic [LINE_W-1:0]    win_line;
  logic                 sel_nmi;
  sched_e               sel_sched;
  logic [VEC_W-1:0]     sel_vec;
  logic [N_THREADS-1:0] sel_aff, elig;
  logic [THR_W-1:0]     sel_lptr, last_thr, pick;
  logic                 unused_cfg;

  assign unused_cfg = ^cfg_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_en_q <= '1;
      gptr_q   <= THR_W'(N_THREADS - 1);
    end else begin
      if (thr_en_we_i) thr_en_q <= thr_en_wdata_i;
      if (dlv && sel_sched == SCHED_GLOBAL) gptr_q <= pick;
    end
  end

  irq_rd_line_bank #(
    .N_LINES(N_LINES), .N_THREADS(N_THREADS), .LINE_W(LINE_W), .THR_W(THR_W)
  ) u_lines (
    .clk_i, .rst_ni, .line_i,
    .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .ack_we_i, .ack_line_i,
    .thr_en_i    (thr_en_q),
    .dlv_i       (dlv),
    .win_line_i  (win_line),
    .dlv_thr_i   (pick),
    .req_o       (req),
    .sel_nmi_o   (sel_nmi),
    .sel_sched_o (sel_sched),
    .sel_vec_o   (sel_vec),
    .sel_aff_o   (sel_aff),
    .sel_lptr_o  (sel_lptr)
  );

  irq_rd_prio_arb #(.N(N_LINES), .W(LINE_W)) u_arb (
    .req_i     (req),
    .gnt_v_o   (arb_v),
    .gnt_idx_o (win_line)
  );

  assign elig     = sel_aff & thr_en_q;
  assign last_thr = (sel_sched == SCHED_GLOBAL) ? gptr_q : sel_lptr;

  irq_rd_rr_pick #(.N(N_THREADS), .W(THR_W)) u_pick (
    .elig_i   (elig),
    .last_i   (last_thr),
    .pick_v_o (pick_v),
    .pick_o   (pick)
  );

  assign dlv = arb_v & pick_v;

  irq_rd_pend_bank #(.N_THREADS(N_THREADS), .THR_W(THR_W)) u_pend (
    .clk_i, .rst_ni,
    .set_v_i    (dlv & ~sel_nmi),
    .nmi_v_i    (dlv & sel_nmi),
    .thr_i      (pick),
    .vec_i      (sel_vec),
    .clr_we_i, .clr_thr_i, .clr_mask_i,
    .pend_o, .nmi_o
  );

  p_pick_found_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_v |-> pick_v);
  p_thr_allowed_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlv |-> (thr_en_q[pick] && sel_aff[pick]));
endmodule

// File: tb/irq_redirect_ctrl_test.sv
`timescale 1ns/1ps
module irq_redirect_ctrl_test;
  localparam int NL = 8;
  localparam int NT = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NL-1:0] line = '0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [31:0]   cfg_data = '0;
  logic          ten_we = 1'b0;
  logic [NT-1:0] ten_data = '0;
  logic          ack_we = 1'b0;
  logic [2:0]    ack_line = '0;
  logic          clr_we = 1'b0;
  logic [1:0]    clr_thr = '0;
  logic [63:0]   clr_mask = '0;
  logic [NT*64-1:0] pend;
  logic [NT-1:0] nmi;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_redirect_ctrl #(.N_LINES(NL), .N_THREADS(NT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_data),
    .thr_en_we_i(ten_we), .thr_en_wdata_i(ten_data),
    .ack_we_i(ack_we), .ack_line_i(ack_line),
    .clr_we_i(clr_we), .clr_thr_i(clr_thr), .clr_mask_i(clr_mask),
    .pend_o(pend), .nmi_o(nmi)
  );

  function automatic logic [31:0] mk(bit en, bit nm, bit glb, bit edg, int v, int aff);
    return 32'(en) | (32'(nm) << 1) | (32'(glb) << 2) | (32'(edg) << 3)
         | (32'(v & 63) << 4) | (32'(aff & 16'hffff) << 16);
  endfunction

  function automatic logic [63:0] pw(int t);
    return pend[t*64 +: 64];
  endfunction

  function automatic int owner(int v);
    int r = -1;
    for (int t = 0; t < NT; t++) if (pend[t*64 + v]) r = t;
    return r;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfg(int l, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = 3'(l); cfg_data = d; tick(1); cfg_we = 1'b0;
  endtask

  task automatic ack(int l);
    ack_we = 1'b1; ack_line = 3'(l); tick(1); ack_we = 1'b0;
  endtask

  task automatic clr(int t, logic [63:0] m);
    clr_we = 1'b1; clr_thr = 2'(t); clr_mask = m; tick(1); clr_we = 1'b0;
  endtask

  task automatic ten(logic [NT-1:0] m);
    ten_we = 1'b1; ten_data = m; tick(1); ten_we = 1'b0;
  endtask

  task automatic shoot(int l);
    line[l] = 1'b1; tick(4); line[l] = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int cnt, oth, exp_t;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check("R1 pending after reset", 64'(|pend), 64'd0);
    check("R1 nmi after reset", 64'(nmi), 64'd0);

    // R2: reset entry and explicitly disabled entry stay silent
    line[3] = 1'b1; tick(5);
    check("R2 reset entry silent", 64'(|pend), 64'd0);
    cfg(3, mk(0, 0, 0, 0, 3, 4'hf)); tick(5);
    check("R2 disabled entry silent", 64'(|pend | |nmi), 64'd0);
    line[3] = 1'b0; tick(2);

    // R3/R11 sweep over every line
    for (int i = 0; i < NL; i++) begin
      int t, v;
      t = i % NT; v = (i * 9 + 2) % 64;
      cfg(i, mk(1, 0, 0, 0, v, 1 << t));
      line[i] = 1'b1; tick(2);
      check("R3 level delivery at second edge", pw(t), 64'd1 << v);
      check("R3 other threads idle", 64'(|pend) & 64'(pend != {{((NT-1)*64){1'b0}}, 64'd0} ? (pend ^ (256'(pw(t)) << (t*64))) != 0 : 1'b0), 64'd0);
      line[i] = 1'b0;
      clr(t, 64'd1 << v);
      check("R11 clear removes bit", pw(t), 64'd0);
      ack(i);
    end

    // R4: blocking until acknowledge
    cfg(0, mk(1, 0, 0, 0, 5, 4'b0001));
    line[0] = 1'b1; tick(4);
    check("R4 first delivery", pw(0), 64'd1 << 5);
    clr(0, 64'd1 << 5); tick(4);
    check("R4 blocked while in service", pw(0), 64'd0);
    ack(0); tick(2);
    check("R4 redelivered after ack", pw(0), 64'd1 << 5);
    line[0] = 1'b0; clr(0, '1); ack(0);

    // R5: edge kept across in-service window
    cfg(1, mk(1, 0, 0, 1, 9, 4'b0010));
    shoot(1); tick(4);
    check("R5 edge delivered once", pw(1), 64'd1 << 9);
    clr(1, 64'd1 << 9);
    shoot(1); tick(2);
    check("R5 edge held while in service", pw(1), 64'd0);
    ack(1); tick(2);
    check("R5 kept edge delivered after ack", pw(1), 64'd1 << 9);
    clr(1, '1); ack(1); tick(4);
    check("R5 no repeat without new edge", pw(1), 64'd0);

    // R6: lowest index first, one per cycle
    cfg(2, mk(1, 0, 0, 0, 20, 4'b0100));
    cfg(5, mk(1, 0, 0, 0, 21, 4'b0100));
    line[2] = 1'b1; line[5] = 1'b1; tick(2);
    check("R6 lowest line first", pw(2), 64'd1 << 20);
    tick(1);
    check("R6 second line next cycle", pw(2), (64'd1 << 20) | (64'd1 << 21));
    line[2] = 1'b0; line[5] = 1'b0;
    clr(2, '1); ack(2); ack(5);

    // R11: set wins over same-cycle clear
    line[2] = 1'b1; tick(1);
    clr(2, 64'd1 << 20);
    check("R11 set wins on collision", pw(2), 64'd1 << 20);
    line[2] = 1'b0; clr(2, '1); ack(2);

    // R7: shared pointer across two lines
    cfg(6, mk(1, 0, 1, 1, 30, 4'hf));
    cfg(7, mk(1, 0, 1, 1, 31, 4'hf));
    for (int k = 0; k < 8; k++) begin
      int l, v;
      l = 6 + k % 2; v = 30 + k % 2;
      shoot(l); tick(1);
      check("R7 shared rotation", 64'(owner(v)), 64'(k % NT));
      clr(k % NT, '1); ack(l);
    end

    // R8: per-line pointer
    cfg(4, mk(1, 0, 0, 1, 40, 4'b1010));
    for (int k = 0; k < 4; k++) begin
      exp_t = (k % 2 == 0) ? 1 : 3;
      shoot(4); tick(1);
      check("R8 per-line rotation", 64'(owner(40)), 64'(exp_t));
      clr(exp_t, '1); ack(4);
    end
    cfg(3, mk(1, 0, 0, 1, 41, 4'hf));
    shoot(3); tick(1);
    check("R8 other line pointer independent", 64'(owner(41)), 64'd0);
    clr(0, '1); ack(3);

    // R9/R12: waiting request and skipped threads
    ten(4'b1110);
    cfg(6, mk(1, 0, 1, 1, 30, 4'b0001));
    shoot(6); tick(2);
    check("R9 no permitted thread waits", 64'(|pend), 64'd0);
    shoot(2); tick(1);
    check("R9 other line not blocked", pw(2), 64'd1 << 20);
    clr(2, '1); ack(2);
    ten(4'b1111); tick(3);
    check("R12 waiting request resumes", pw(0), 64'd1 << 30);
    clr(0, '1); ack(6);
    ten(4'b1011);
    shoot(7); tick(1);
    check("R12 shared pointer next", 64'(owner(31)), 64'd1);
    clr(1, '1); ack(7);
    shoot(7); tick(1);
    check("R12 disabled thread skipped", 64'(owner(31)), 64'd3);
    clr(3, '1); ack(7);
    ten(4'b1111);

    // R10: NMI pulse
    cfg(0, mk(1, 1, 0, 0, 5, 4'b1000));
    line[0] = 1'b1; cnt = 0; oth = 0;
    for (int k = 0; k < 6; k++) begin
      tick(1);
      if (nmi == 4'b1000) cnt++;
      else if (nmi != 0) oth++;
    end
    check("R10 single nmi pulse", 64'(cnt), 64'd1);
    check("R10 nmi on chosen thread only", 64'(oth), 64'd0);
    check("R10 pending untouched", 64'(|pend), 64'd0);
    line[0] = 1'b0; ack(0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule